// File: doc/BRIEF.md
# Flash Status Read Controller

This block fetches the 8-bit status byte from a parallel AND-type flash device over its 8-bit I/O bus. To start a read, it pulls an active-low output-enable strobe low for a programmable number of clock cycles. It samples the bus on the final low cycle and keeps the byte in a status field that the CPU can read. A read starts in one of two ways: software asks for one, or a program operation finishes while the auto-status option is set. The auto-status start works the same whatever access mode the surrounding controller used for programming.

The captured byte is decoded into three flags: ready/busy, erase check and program check. If either check bit reports a failure, a sticky error flag is set. This flag stays set until software clears it. An interrupt request is active while the error flag and its enable are both set. A one-cycle done pulse marks the end of each capture. Requests that arrive while a read is running are dropped.

Top module: `flashStatusReader`

## Requirements
- R1: After reset, oeN is 1, statusByte is 0x00, errFlag, irq and done are 0.
- R2: A cycle with swReq=1 while idle starts a read: oeN is low for exactly oeLowCycles consecutive cycles (a value of 0 acts as 1), then returns high.
- R3: statusByte takes the value of ioIn sampled on the last cycle in which oeN is low, and holds it until the next capture.
- R4: A progDone pulse starts a read when autoStatusEn=1. When autoStatusEn=0, a progDone pulse has no effect: oeN stays high and done stays 0.
- R5: ready equals statusByte bit 7 (1 = ready, 0 = busy). eraseFail equals bit 5 and progFail equals bit 4 (1 = failure).
- R6: A capture in which bit 5 or bit 4 is 1 sets errFlag. Bit 6 and bits 3..0 do not affect errFlag.
- R7: errFlag stays 1 until a cycle with errClr=1. If a set and a clear happen in the same cycle, the set wins.
- R8: irq is 1 exactly when errFlag=1 and errIntEn=1.
- R9: done is high for one cycle, in the cycle right after each capture. Read requests (swReq or auto) that arrive while oeN is low are ignored and produce no extra read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioIn | input | 8 | Flash I/O bus, read direction |
| swReq | input | 1 | Software status-read request |
| progDone | input | 1 | Pulse marking the end of a program operation |
| autoStatusEn | input | 1 | Auto-status option: read after programming |
| oeLowCycles | input | CNT_W | Number of cycles the strobe is held low |
| errClr | input | 1 | Software clear of the error flag |
| errIntEn | input | 1 | Error interrupt enable |
| oeN | output | 1 | Active-low output-enable strobe to the flash |
| statusByte | output | 8 | Last captured status byte |
| ready | output | 1 | Decoded ready/busy bit |
| eraseFail | output | 1 | Decoded erase-check failure |
| progFail | output | 1 | Decoded program-check failure |
| errFlag | output | 1 | Sticky status-error flag |
| irq | output | 1 | Status-error interrupt request |
| done | output | 1 | One-cycle capture-complete pulse |

## Verification
A fault in the strobe counter appears immediately at oeN: the strobe is low for the wrong number of cycles, and done arrives early or late in the same read. A fault in the capture path or the error register appears in the cycle after capture, as a wrong statusByte, errFlag or irq. Because errFlag is sticky, a missed set or a missed clear persists and is caught at the next check. A state machine that wrongly accepts a new request mid-read shows up within a few cycles as extra strobe cycles or a second done pulse.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int STAT_W = 8;
  localparam int READY_BIT = 7;
  localparam int ERASE_BIT = 5;
  localparam int PROG_BIT = 4;

  typedef struct packed {
    logic oeActive;
    logic capture;
  } rdStrobes_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_STROBE = 1'b1
  } rdState_t;
endpackage

// File: rtl/flash_stat_ctrl.sv
module flash_stat_ctrl
  import flash_stat_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] oeLowCycles,
  output rdStrobes_t       strobes
);
  rdState_t   state;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] loadVal;

  // zero requested width behaves as a single cycle
  always_comb begin
    loadVal = (oeLowCycles == '0) ? '0 : oeLowCycles - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state  <= ST_STROBE;
            remain <= loadVal;
          end
        end
        ST_STROBE: begin
          if (remain == '0) begin
            state <= ST_IDLE;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.oeActive = (state == ST_STROBE);
    strobes.capture  = (state == ST_STROBE) && (remain == '0);
  end
endmodule

// File: rtl/flash_stat_dp.sv
module flash_stat_dp
  import flash_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] ioIn,
  input  rdStrobes_t        strobes,
  input  logic              errClr,
  input  logic              errIntEn,
  output logic [STAT_W-1:0] statusByte,
  output logic              ready,
  output logic              eraseFail,
  output logic              progFail,
  output logic              errFlag,
  output logic              irq,
  output logic              done
);
  logic failSeen;

  always_comb begin
    failSeen = ioIn[ERASE_BIT] | ioIn[PROG_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusByte <= '0;
      errFlag    <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= strobes.capture;
      if (strobes.capture) begin
        statusByte <= ioIn;
      end
      if (strobes.capture && failSeen) begin
        errFlag <= 1'b1;
      end else if (errClr) begin
        errFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    ready     = statusByte[READY_BIT];
    eraseFail = statusByte[ERASE_BIT];
    progFail  = statusByte[PROG_BIT];
    irq       = errFlag & errIntEn;
  end
endmodule

// File: rtl/flashStatusReader.sv
module flashStatusReader
  import flash_stat_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       ioIn,
  input  logic             swReq,
  input  logic             progDone,
  input  logic             autoStatusEn,
  input  logic [CNT_W-1:0] oeLowCycles,
  input  logic             errClr,
  input  logic             errIntEn,
  output logic             oeN,
  output logic [7:0]       statusByte,
  output logic             ready,
  output logic             eraseFail,
  output logic             progFail,
  output logic             errFlag,
  output logic             irq,
  output logic             done
);
  rdStrobes_t strobes;
  logic startReq;

  always_comb begin
    startReq = swReq | (autoStatusEn & progDone);
    oeN      = ~strobes.oeActive;
  end

  flash_stat_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .oeLowCycles(oeLowCycles), .strobes(strobes)
  );

  flash_stat_dp i_dp (
    .clk(clk), .rstN(rstN), .ioIn(ioIn), .strobes(strobes),
    .errClr(errClr), .errIntEn(errIntEn), .statusByte(statusByte),
    .ready(ready), .eraseFail(eraseFail), .progFail(progFail),
    .errFlag(errFlag), .irq(irq), .done(done)
  );
endmodule

// File: rtl/flashStatusReader_chk.sv
module flashStatusReader_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] ioIn,
  input logic       errClr,
  input logic       oeN,
  input logic [7:0] statusByte,
  input logic       errFlag,
  input logic       irq,
  input logic       done
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_oe_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> oeN);

  p_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> statusByte == $past(ioIn));

  p_err_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && (statusByte[5] || statusByte[4])) |-> errFlag);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);

  p_irq_needs_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    !errFlag |-> !irq);
endmodule

bind flashStatusReader flashStatusReader_chk i_chk (
  .clk(clk), .rstN(rstN), .ioIn(ioIn), .errClr(errClr), .oeN(oeN),
  .statusByte(statusByte), .errFlag(errFlag), .irq(irq), .done(done)
);

// File: tb/test_flashStatusReader.sv
module test_flashStatusReader;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] ioIn = 8'h00;
  logic       swReq = 1'b0;
  logic       progDone = 1'b0;
  logic       autoStatusEn = 1'b0;
  logic [3:0] oeLowCycles = 4'd2;
  logic       errClr = 1'b0;
  logic       errIntEn = 1'b0;
  logic       oeN, ready, eraseFail, progFail, errFlag, irq, done;
  logic [7:0] statusByte;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  flashStatusReader i_flashStatusReader (
    .clk(clk), .rstN(rstN), .ioIn(ioIn), .swReq(swReq), .progDone(progDone),
    .autoStatusEn(autoStatusEn), .oeLowCycles(oeLowCycles), .errClr(errClr),
    .errIntEn(errIntEn), .oeN(oeN), .statusByte(statusByte), .ready(ready),
    .eraseFail(eraseFail), .progFail(progFail), .errFlag(errFlag), .irq(irq),
    .done(done)
  );

  // vector: [10]=auto start, [9]=irq enable, [8]=expected error, [7:0]=status byte
  localparam logic [10:0] VECS [8] = '{
    {1'b0, 1'b1, 1'b0, 8'h80},
    {1'b0, 1'b1, 1'b1, 8'h90},
    {1'b1, 1'b1, 1'b1, 8'hA0},
    {1'b1, 1'b0, 1'b1, 8'hB0},
    {1'b0, 1'b1, 1'b0, 8'h4F},
    {1'b1, 1'b1, 1'b0, 8'hCF},
    {1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'h30}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // starts a read and counts strobe-low cycles; returns at the negedge after capture
  task automatic runRead(input logic [7:0] b, input bit useAuto,
                         output int lowCnt, output bit sawDone);
    @(negedge clk);
    ioIn = b;
    if (useAuto) progDone = 1'b1; else swReq = 1'b1;
    @(negedge clk);
    progDone = 1'b0;
    swReq = 1'b0;
    lowCnt = 0;
    while (oeN == 1'b0 && lowCnt < 40) begin
      lowCnt++;
      @(negedge clk);
    end
    sawDone = done;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lowCnt;
    bit sawDone;
    int doneCnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oeN", oeN, 1);
    check("R1 statusByte", statusByte, 0);
    check("R1 errFlag", errFlag, 0);
    check("R1 irq", irq, 0);
    check("R1 done", done, 0);
    rstN = 1'b1;
    autoStatusEn = 1'b1;

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      errClr = 1'b1;
      errIntEn = VECS[i][9];
      @(negedge clk);
      errClr = 1'b0;
      runRead(VECS[i][7:0], VECS[i][10], lowCnt, sawDone);
      check("R2 low cycles", lowCnt, 2);
      check("R9 done", sawDone, 1);
      check("R3 statusByte", statusByte, VECS[i][7:0]);
      check("R5 ready", ready, VECS[i][7]);
      check("R5 eraseFail", eraseFail, VECS[i][5]);
      check("R5 progFail", progFail, VECS[i][4]);
      check("R6 errFlag", errFlag, VECS[i][8]);
      check("R8 irq", irq, VECS[i][8] & VECS[i][9]);
      @(negedge clk);
      check("R9 done one cycle", done, 0);
    end

    // R7 sticky: error set, then a passing read keeps it
    errIntEn = 1'b1;
    runRead(8'h90, 1'b0, lowCnt, sawDone);
    runRead(8'h80, 1'b0, lowCnt, sawDone);
    check("R7 sticky errFlag", errFlag, 1);
    check("R8 irq sticky", irq, 1);
    errIntEn = 1'b0;
    @(negedge clk);
    check("R8 irq masked", irq, 0);
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
    check("R7 clear", errFlag, 0);

    // R7 set wins over clear in the same cycle
    errClr = 1'b1;
    runRead(8'hA0, 1'b0, lowCnt, sawDone);
    check("R7 set beats clear", errFlag, 1);
    @(negedge clk);
    errClr = 1'b0;
    check("R7 clear after", errFlag, 0);

    // R4 progDone ignored when auto-status off
    autoStatusEn = 1'b0;
    @(negedge clk);
    progDone = 1'b1;
    ioIn = 8'hFF;
    @(negedge clk);
    progDone = 1'b0;
    check("R4 no strobe", oeN, 1);
    @(negedge clk);
    check("R4 oeN high", oeN, 1);
    check("R4 no done", done, 0);
    @(negedge clk);
    check("R4 status unchanged", statusByte, 8'hA0);

    // R2 zero width acts as one cycle
    oeLowCycles = 4'd0;
    runRead(8'h81, 1'b0, lowCnt, sawDone);
    check("R2 zero width", lowCnt, 1);
    check("R3 zero width capture", statusByte, 8'h81);

    // R2 longer width
    oeLowCycles = 4'd5;
    runRead(8'h82, 1'b0, lowCnt, sawDone);
    check("R2 width five", lowCnt, 5);
    check("R9 done width five", sawDone, 1);

    // R3 sample taken on last low cycle
    oeLowCycles = 4'd2;
    @(negedge clk);
    ioIn = 8'h11;
    swReq = 1'b1;
    @(negedge clk);
    swReq = 1'b0;
    ioIn = 8'hC4;
    @(negedge clk);
    @(negedge clk);
    check("R3 last cycle sample", statusByte, 8'hC4);

    // R9 requests during a read are ignored
    oeLowCycles = 4'd4;
    doneCnt = 0;
    lowCnt = 0;
    @(negedge clk);
    ioIn = 8'h80;
    swReq = 1'b1;
    autoStatusEn = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 2) begin
        swReq = 1'b0;
        progDone = 1'b1;
      end
      if (k == 3) progDone = 1'b0;
      if (oeN == 1'b0) lowCnt++;
      if (done) doneCnt++;
    end
    check("R9 single strobe", lowCnt, 4);
    check("R9 single done", doneCnt, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule